// File: doc/BRIEF.md
# Write-Only Serial Configuration Register Slave

This block is a slave on a two-wire I2C bus that only accepts writes. A host loads it with eight 8-bit control settings for a video signal path: contrast, brightness, three per-channel gains, an output DC level, an overlay gain and a clamp/miscellaneous byte. The block oversamples the bus lines with its own system clock. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds START and STOP conditions and clock edges, and it steps a small state machine through the frame. The settings appear as parallel buses to downstream logic.

A transfer is: START, the address byte 0xDC (7-bit address 1101110 with R/W=0), a sub-address byte, one data byte, then STOP. The slave acknowledges each accepted byte by pulling SDA low during the ninth clock. Bits arrive most significant first. After reset every register holds its power-on value.

The states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK, ST_DATA, ST_DATA_ACK and ST_SKIP. The transitions are:
- A START from any state leads to ST_ADDR, and a STOP from any state leads to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK after eight bits that match the address, and to ST_SKIP otherwise.
- ST_SUB goes to ST_SUB_ACK, and ST_DATA goes to ST_DATA_ACK, after eight bits each.
- Each ack state leaves on the next falling SCL edge: ST_ADDR_ACK to ST_SUB, ST_SUB_ACK to ST_DATA, ST_DATA_ACK to ST_SKIP.
- ST_SKIP waits, without acknowledging anything, for the next START or STOP.

Top module: `cfg_i2c_wslave`

## Requirements
- R1: After reset, sub-addresses 0x01 to 0x05 read 0xB4, 0x06 and 0x07 read 0x08, 0x08 reads 0x04, and sda_pull_o is 0.
- R2: A complete transfer (address 0xDC, sub-address s in 0x01..0x08, data d) puts d on the output of register s once the data byte's ninth clock has begun.
- R3: The slave sets sda_pull_o to 1 while SCL is high in the ninth clock of the address byte 0xDC, of the sub-address byte that follows, and of the first data byte. It is 0 at all other times.
- R4: An address byte other than 0xDC, including the read request 0xDD, is not acknowledged. No register changes for the rest of that transfer.
- R5: A sub-address outside 0x01..0x08 is acknowledged, along with its data byte, but no register changes.
- R6: Registers 0x06 and 0x07 keep only the low four bits of written data, and their upper four output bits read as 0.
- R7: A STOP or a START that arrives partway through a byte ends the transfer with no register update. A START begins a new address phase, and that new transfer completes normally.
- R8: A pulse on SCL that lasts fewer system clocks than the filter length (3) has no effect on the received bytes.
- R9: After the first data byte, further bytes are neither acknowledged nor written, until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| contrast_o | output | 8 | Register 0x01 |
| bright_o | output | 8 | Register 0x02 |
| gain0_o | output | 8 | Register 0x03 |
| gain1_o | output | 8 | Register 0x04 |
| gain2_o | output | 8 | Register 0x05 |
| dclevel_o | output | 8 | Register 0x06, upper nibble 0 |
| ovlgain_o | output | 8 | Register 0x07, upper nibble 0 |
| clampcfg_o | output | 8 | Register 0x08 |

## Verification
A bit counter or state that has slipped shows up within one byte. The acknowledge then falls in the wrong clock or is missing, and the bench samples sda_pull_o in every ninth clock. A wrong sub-address capture or a wrong write enable shows up as soon as the transfer's STOP, when all eight output buses are compared against a bench model. An abort that fails to clear the frame shows up on the next write as a missing acknowledge or a register that changed when it should not have.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int NUM_REGS = 8;
    localparam int REG_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } xfer_state_t;

    // Power-on value of register slot idx (slot 0 is sub-address 0x01)
    function automatic logic [REG_W-1:0] por_value(input int idx);
        if (idx <= 4)      return 8'hB4;
        else if (idx <= 6) return 8'h08;
        else               return 8'h04;
    endfunction

    // Bits a slot keeps: the two 4-bit settings hold the low nibble only
    function automatic logic [REG_W-1:0] keep_mask(input int idx);
        if (idx == 5 || idx == 6) return 8'h0F;
        else                      return 8'hFF;
    endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0]   sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[STAGES-1]};
            if (&hist_q)       dout <= 1'b1;
            else if (~|hist_q) dout <= 1'b0;
        end
    end

    // R8: the filtered level only moves after FILT_LEN agreeing samples
    a_r8_filter_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(hist_q) == {FILT_LEN{dout}}));

endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl,
    input  logic             sda,
    output logic             sda_pull_o,
    output logic             wr_en_o,
    output logic [REG_W-1:0] wr_addr_o,
    output logic [REG_W-1:0] wr_data_o
);
    localparam logic [REG_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam int CNT_W = $clog2(REG_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(REG_W);

    xfer_state_t      state, next_state;
    logic             scl_d, sda_d;
    logic [REG_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             scl_rise, scl_fall, start_det, stop_det, byte_done, rx_state;

    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
    assign byte_done = scl_fall && (cnt == FULL);
    assign rx_state  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

    always_comb begin
        next_state = state;
        if (stop_det) begin
            next_state = ST_IDLE;
        end else if (start_det) begin
            next_state = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     next_state = ST_IDLE;
                ST_ADDR:     if (byte_done) next_state = (shreg == ADDR_BYTE) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)  next_state = ST_SUB;
                ST_SUB:      if (byte_done) next_state = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  next_state = ST_DATA;
                ST_DATA:     if (byte_done) next_state = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  next_state = ST_SKIP;
                ST_SKIP:     next_state = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d      <= 1'b1;
            sda_d      <= 1'b1;
            shreg      <= '0;
            cnt        <= '0;
            sda_pull_o <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            scl_d      <= scl;
            sda_d      <= sda;
            sda_pull_o <= (next_state == ST_ADDR_ACK) || (next_state == ST_SUB_ACK) ||
                          (next_state == ST_DATA_ACK);
            wr_en_o    <= (state == ST_DATA) && (next_state == ST_DATA_ACK);
            if (state == ST_SUB && next_state == ST_SUB_ACK) wr_addr_o <= shreg;
            if (state == ST_DATA && next_state == ST_DATA_ACK) wr_data_o <= shreg;
            if (start_det || stop_det || (state != next_state)) begin
                cnt <= '0;
            end else if (scl_rise && rx_state) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[REG_W-2:0], sda};
            end
        end
    end

    // R3: an acknowledge starts only right after a full byte
    a_r3_ack_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> ($past(cnt) == FULL));
    // R7: STOP always returns to idle
    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
    // R7: START always restarts the address phase with a cleared count
    a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_ADDR && cnt == '0));
    // R9: a write coincides with the one data acknowledge
    a_r9_write_in_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (state == ST_DATA_ACK && sda_pull_o));

endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
    import cfg_i2c_pkg::*;
#(
    parameter int BASE_ADDR = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REG_W-1:0]               wr_addr,
    input  logic [REG_W-1:0]               wr_data,
    output logic [NUM_REGS-1:0][REG_W-1:0] q_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] SLOT_ADDR = REG_W'(BASE_ADDR + i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q_o[i] <= por_value(i);
            else if (wr_en && (wr_addr == SLOT_ADDR))  q_o[i] <= wr_data & keep_mask(i);
        end
    end

    // R2/R5: registers hold unless a write strobe was present
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q_o));
    // R6: the nibble settings never show upper bits
    a_r6_upper_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o[5][7:4] == 4'h0) && (q_o[6][7:4] == 4'h0));

endmodule

// File: rtl/cfg_i2c_wslave.sv
module cfg_i2c_wslave
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h6E,
    parameter int         STAGES    = 2,
    parameter int         FILT_LEN  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [7:0] contrast_o,
    output logic [7:0] bright_o,
    output logic [7:0] gain0_o,
    output logic [7:0] gain1_o,
    output logic [7:0] gain2_o,
    output logic [7:0] dclevel_o,
    output logic [7:0] ovlgain_o,
    output logic [7:0] clampcfg_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0]           raw_lines, clean_lines;
    logic                           wr_en;
    logic [REG_W-1:0]               wr_addr, wr_data;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        cfg_i2c_sync #(.STAGES(STAGES), .FILT_LEN(FILT_LEN)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[l]),
            .dout (clean_lines[l])
        );
    end

    cfg_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (clean_lines[0]),
        .sda       (clean_lines[1]),
        .sda_pull_o(sda_pull_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    cfg_i2c_regbank #(.BASE_ADDR(1)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .q_o    (regs)
    );

    assign contrast_o = regs[0];
    assign bright_o   = regs[1];
    assign gain0_o    = regs[2];
    assign gain1_o    = regs[3];
    assign gain2_o    = regs[4];
    assign dclevel_o  = regs[5];
    assign ovlgain_o  = regs[6];
    assign clampcfg_o = regs[7];

endmodule

// File: tb/cfg_i2c_wslave_bench.sv
module cfg_i2c_wslave_bench;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_tb = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_pull;
    logic sda_bus;
    logic [7:0] o_contrast, o_bright, o_g0, o_g1, o_g2, o_dc, o_ovl, o_clamp;
    int checks = 0;
    int errors = 0;
    logic [7:0] model [1:8];

    always #5 clk = ~clk;
    assign sda_bus = sda_tb & ~sda_pull;

    cfg_i2c_wslave u_cfg_i2c_wslave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_bus),
        .sda_pull_o(sda_pull),
        .contrast_o(o_contrast), .bright_o(o_bright), .gain0_o(o_g0),
        .gain1_o(o_g1), .gain2_o(o_g2), .dclevel_o(o_dc),
        .ovlgain_o(o_ovl), .clampcfg_o(o_clamp)
    );

    function automatic logic [7:0] exp_por(input int s);
        if (s <= 5) return 8'hB4;
        if (s <= 7) return 8'h08;
        return 8'h04;
    endfunction

    function automatic logic [7:0] exp_mask(input int s);
        return (s == 6 || s == 7) ? 8'h0F : 8'hFF;
    endfunction

    function automatic logic [7:0] port_of(input int s);
        case (s)
            1: return o_contrast;
            2: return o_bright;
            3: return o_g0;
            4: return o_g1;
            5: return o_g2;
            6: return o_dc;
            7: return o_ovl;
            default: return o_clamp;
        endcase
    endfunction

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int s = 1; s <= 8; s++)
            chk(req, port_of(s), model[s], $sformatf("reg 0x%0h", s));
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; wait_c(Q);
        scl_tb = 1'b1; wait_c(Q);
        sda_tb = 1'b0; wait_c(Q);
        scl_tb = 1'b0; wait_c(Q);
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; wait_c(Q);
        scl_tb = 1'b1; wait_c(Q);
        sda_tb = 1'b1; wait_c(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            sda_tb = b[i];
            if (glitch) begin
                wait_c(10); scl_tb = 1'b1; wait_c(1); scl_tb = 1'b0; wait_c(Q-11);
            end else begin
                wait_c(Q);
            end
            scl_tb = 1'b1; wait_c(2*Q);
            scl_tb = 1'b0; wait_c(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        send_bits(b, 8, glitch);
        sda_tb = 1'b1; wait_c(Q);
        scl_tb = 1'b1; wait_c(Q);
        acked = sda_pull;
        wait_c(Q);
        scl_tb = 1'b0; wait_c(Q);
    endtask

    task automatic write_xfer(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                              input bit glitch, input string req);
        bit k0, k1, k2;
        bit ok;
        ok = (a == 8'hDC);
        bus_start();
        send_byte(a, glitch, k0);
        send_byte(s, glitch, k1);
        send_byte(d, glitch, k2);
        bus_stop();
        chk(req, k0, ok, "address ack");
        chk(req, k1, ok, "sub-address ack");
        chk(req, k2, ok, "data ack");
        if (ok && s >= 1 && s <= 8) model[s] = d & exp_mask(s);
        check_regs(req);
        chk(req, sda_pull, 1'b0, "pull released after stop");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit k;
        void'($urandom(32'h5EED_1234));
        for (int s = 1; s <= 8; s++) model[s] = exp_por(s);
        wait_c(5);
        rst_n = 1'b1;
        wait_c(5);

        // R1: reset values and idle acknowledge line
        check_regs("R1");
        chk("R1", sda_pull, 1'b0, "pull at reset");

        // R2/R3: write each register once
        write_xfer(8'hDC, 8'h01, 8'h5A, 1'b0, "R2");
        for (int s = 2; s <= 8; s++)
            write_xfer(8'hDC, 8'(s), 8'(8'h30 + s * 17), 1'b0, "R3");

        // R6: nibble registers drop the upper bits
        write_xfer(8'hDC, 8'h06, 8'hFF, 1'b0, "R6");
        write_xfer(8'hDC, 8'h07, 8'hA3, 1'b0, "R6");

        // R4: read request and foreign address are refused
        write_xfer(8'hDD, 8'h01, 8'h11, 1'b0, "R4");
        write_xfer(8'hDE, 8'h02, 8'h22, 1'b0, "R4");

        // R5: sub-addresses outside the map
        write_xfer(8'hDC, 8'h00, 8'h77, 1'b0, "R5");
        write_xfer(8'hDC, 8'h09, 8'h77, 1'b0, "R5");
        write_xfer(8'hDC, 8'hFF, 8'h77, 1'b0, "R5");

        // R7: STOP in the middle of the data byte
        bus_start();
        send_byte(8'hDC, 1'b0, k);
        send_byte(8'h01, 1'b0, k);
        send_bits(8'hE1, 4, 1'b0);
        bus_stop();
        check_regs("R7");
        // R7: START in the middle of a data byte, then a full write
        bus_start();
        send_byte(8'hDC, 1'b0, k);
        send_byte(8'h02, 1'b0, k);
        send_bits(8'h99, 3, 1'b0);
        check_regs("R7");
        write_xfer(8'hDC, 8'h03, 8'h3C, 1'b0, "R7");

        // R8: single-cycle SCL glitches in every low phase
        write_xfer(8'hDC, 8'h04, 8'hC5, 1'b1, "R8");

        // R9: second data byte refused and not written
        bus_start();
        send_byte(8'hDC, 1'b0, k);
        send_byte(8'h02, 1'b0, k);
        send_byte(8'h11, 1'b0, k);
        chk("R9", k, 1'b1, "first data ack");
        send_byte(8'h22, 1'b0, k);
        chk("R9", k, 1'b0, "second data ack");
        bus_stop();
        model[2] = 8'h11;
        check_regs("R9");

        // R2/R4/R5: constrained random transfers
        for (int n = 0; n < 20; n++) begin
            logic [7:0] a, s, d;
            a = ($urandom_range(0, 9) == 0) ? 8'hDD : 8'hDC;
            s = 8'($urandom_range(0, 10));
            d = 8'($urandom);
            write_xfer(a, s, d, 1'b0, "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule